// File: doc/BRIEF.md
# Tribble-wise SIMD multiply unit

This block is one registered arithmetic slice of a 36-bit datapath. It splits each operand into six 6-bit lanes ("tribbles"). It multiplies the lanes pairwise as unsigned numbers, and from each 12-bit lane product it keeps the upper half, the lower half, or both. Software builds a short multiply (one factor of at most six bits) by adding a rotated high-half result to a low-half result. It builds a full 36x36 multiply from the split forms together with a shift helper that folds a carry.

Each operation takes two 36-bit operands, a 4-bit operation code and the incoming flag vector. The flag vector is bit 3 N (negative), bit 2 Z (zero), bit 1 T (carry/overflow) and bit 0 R (sticky overflow). When `valid_i` is high, the results and the new flags are captured on the rising clock edge, and they appear on the outputs in the cycle after the strobe. Operation codes: 0 low-half multiply, 1 high-half multiply with rotate, 2 high-half multiply without shift, 3 split multiply, 4..9 split multiply with lane k = code-4 of operand A broadcast, 10 double shift left. Codes 11..15 are undefined.

Top module: `tmul_unit`

## Requirements
- R1: Lane k occupies bits 6k+5..6k. Code 0 writes the low 6 bits of (A lane k × B lane k) into lane k of `res_hi_o`. N is cleared, Z is set exactly when that result is zero, and T and R pass through unchanged.
- R2: Code 2 writes the high 6 bits of each lane product into the same lane of `res_hi_o`. Its flags behave as in R1.
- R3: Code 1 assembles the high 6 bits of each lane product into a 36-bit word and rotates it left by 6. N is cleared, and Z is set exactly when the rotated result is zero.
- R4: For code 1, T is set when result bits 5..0 (the bits rotated out of the top) are nonzero, and R is then set too. Otherwise T is cleared and R keeps its incoming value.
- R5: Code 3 puts the high halves of all lane products on `res_hi_o` and the low halves on `res_lo_o` in the same cycle. The flags pass through unchanged.
- R6: Codes 4..9 replace every lane of A with lane (code-4) of A, then perform the R5 operation with R5's flag behaviour.
- R7: Code 10 adds the incoming T bit to B modulo 2^36, shifts the sum left by 6, and fills bits 5..0 with A bits 35..30.
- R8: Code 10 sets N from result bit 35 and Z when the result is zero. T and R pass through unchanged.
- R9: Outputs change only on a rising edge with `valid_i` high. With `valid_i` low they hold their values whatever the other inputs do.
- R10: A synchronous active-low reset clears `res_hi_o`, `res_lo_o` and `flg_o` to zero.
- R11: Codes 11..15 give zero on both result outputs and pass all four flags through unchanged.
- R12: Codes 0, 1, 2 and 10 drive `res_lo_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Capture strobe for one operation |
| op_i | input | 4 | Operation code |
| opa_i | input | 36 | Left operand A |
| opb_i | input | 36 | Right operand B |
| flg_i | input | 4 | Incoming flags {N,Z,T,R} |
| res_hi_o | output | 36 | Main result, or high halves for split forms |
| res_lo_o | output | 36 | Low halves for split forms, else zero |
| flg_o | output | 4 | Updated flags {N,Z,T,R} |

## Verification
The unit holds state only in its output registers, so any fault appears at the ports in the cycle after the strobe. A wrong lane slice or broadcast index corrupts specific 6-bit fields of a result. A wrong rotation shows up as an off-by-lane result together with a wrong T bit. A wrong pass-through path shows up as flags that differ from the inputs on the split and undefined codes. A failure to hold shows up as an output that moves during a strobe-free cycle in which the inputs were scrambled on purpose.

// File: rtl/tmul_pkg.sv
// Shared definitions for the tribble multiply unit: operation codes and
// flag bit positions. Assumes a 4-bit operation code.
package tmul_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_MUL_LO   = 4'd0,
        OP_MUL_HROT = 4'd1,
        OP_MUL_HI   = 4'd2,
        OP_SPLIT    = 4'd3,
        OP_BCAST0   = 4'd4,
        OP_BCAST5   = 4'd9,
        OP_DSHL     = 4'd10
    } tmul_op_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_T = 1;
    localparam int FLG_R = 0;
    localparam int FLG_W = 4;

endpackage

// File: rtl/tmul_lane.sv
// One lane multiplier: unsigned product of two TRIB_W-bit values, split
// into its upper and lower halves. Purely combinational.
module tmul_lane #(
    parameter int TRIB_W = 6
) (
    input  logic [TRIB_W-1:0] x_i,
    input  logic [TRIB_W-1:0] y_i,
    output logic [TRIB_W-1:0] hi_o,
    output logic [TRIB_W-1:0] lo_o
);
    localparam int PROD_W = 2 * TRIB_W;

    logic [PROD_W-1:0] prod;

    // Full-width unsigned product of the two lanes.
    always_comb begin
        prod = PROD_W'(x_i) * PROD_W'(y_i);
    end

    assign hi_o = prod[PROD_W-1:TRIB_W];
    assign lo_o = prod[TRIB_W-1:0];

endmodule

// File: rtl/tmul_array.sv
// Lane array: optionally broadcasts one lane of A to every position, then
// multiplies lane pairs and packs the upper and lower halves into words.
// Assumes bcast_idx_i < N_TRIB whenever bcast_en_i is high.
module tmul_array #(
    parameter int TRIB_W = 6,
    parameter int N_TRIB = 6
) (
    input  logic [TRIB_W*N_TRIB-1:0]        opa_i,
    input  logic [TRIB_W*N_TRIB-1:0]        opb_i,
    input  logic                            bcast_en_i,
    input  logic [$clog2(N_TRIB)-1:0]       bcast_idx_i,
    output logic [TRIB_W*N_TRIB-1:0]        hi_w_o,
    output logic [TRIB_W*N_TRIB-1:0]        lo_w_o
);
    localparam int IDX_W = $clog2(N_TRIB);

    logic [TRIB_W-1:0] a_lane [N_TRIB];
    logic [TRIB_W-1:0] bc_lane;

    // Picks the lane of A that is broadcast.
    always_comb begin
        bc_lane = '0;
        for (int j = 0; j < N_TRIB; j++) begin
            if (bcast_idx_i == IDX_W'(j)) bc_lane = a_lane[j];
        end
    end

    for (genvar k = 0; k < N_TRIB; k++) begin : g_lane
        logic [TRIB_W-1:0] x_sel;
        assign a_lane[k] = opa_i[k*TRIB_W +: TRIB_W];
        assign x_sel     = bcast_en_i ? bc_lane : a_lane[k];
        tmul_lane #(.TRIB_W(TRIB_W)) u_lane (
            .x_i  (x_sel),
            .y_i  (opb_i[k*TRIB_W +: TRIB_W]),
            .hi_o (hi_w_o[k*TRIB_W +: TRIB_W]),
            .lo_o (lo_w_o[k*TRIB_W +: TRIB_W])
        );
    end

endmodule

// File: rtl/tmul_core.sv
// Operation selector: decodes the code, drives the lane array, forms the
// rotate and shift variants and computes the next flag vector.
// Combinational; the top registers the outputs.
module tmul_core #(
    parameter int TRIB_W = 6,
    parameter int N_TRIB = 6
) (
    input  logic [tmul_pkg::OP_W-1:0]   op_i,
    input  logic [TRIB_W*N_TRIB-1:0]    opa_i,
    input  logic [TRIB_W*N_TRIB-1:0]    opb_i,
    input  logic [tmul_pkg::FLG_W-1:0]  flg_i,
    output logic [TRIB_W*N_TRIB-1:0]    hi_o,
    output logic [TRIB_W*N_TRIB-1:0]    lo_o,
    output logic [tmul_pkg::FLG_W-1:0]  flg_o
);
    import tmul_pkg::*;

    localparam int WORD_W = TRIB_W * N_TRIB;
    localparam int IDX_W  = $clog2(N_TRIB);

    logic              bcast_en;
    logic [OP_W-1:0]   bcast_ofs;
    logic [WORD_W-1:0] hi_w, lo_w, rot_w, dsum, dshl_w;
    logic              ovf;

    // Decodes the broadcast codes and their lane index.
    always_comb begin
        bcast_en  = (op_i >= OP_BCAST0) && (op_i <= OP_BCAST5);
        bcast_ofs = op_i - OP_BCAST0;
    end

    tmul_array #(.TRIB_W(TRIB_W), .N_TRIB(N_TRIB)) u_array (
        .opa_i       (opa_i),
        .opb_i       (opb_i),
        .bcast_en_i  (bcast_en),
        .bcast_idx_i (bcast_ofs[IDX_W-1:0]),
        .hi_w_o      (hi_w),
        .lo_w_o      (lo_w)
    );

    // Forms the rotated high word and the carry-folding shift.
    always_comb begin
        rot_w  = {hi_w[WORD_W-TRIB_W-1:0], hi_w[WORD_W-1 -: TRIB_W]};
        ovf    = |hi_w[WORD_W-1 -: TRIB_W];
        dsum   = opb_i + WORD_W'(flg_i[FLG_T]);
        dshl_w = {dsum[WORD_W-TRIB_W-1:0], opa_i[WORD_W-1 -: TRIB_W]};
    end

    // Selects the result words and the next flags for the operation.
    always_comb begin
        hi_o  = '0;
        lo_o  = '0;
        flg_o = flg_i;
        if (bcast_en || op_i == OP_SPLIT) begin
            hi_o = hi_w;
            lo_o = lo_w;
        end else begin
            case (op_i)
                OP_MUL_LO: begin
                    hi_o         = lo_w;
                    flg_o[FLG_N] = 1'b0;
                    flg_o[FLG_Z] = (lo_w == '0);
                end
                OP_MUL_HI: begin
                    hi_o         = hi_w;
                    flg_o[FLG_N] = 1'b0;
                    flg_o[FLG_Z] = (hi_w == '0);
                end
                OP_MUL_HROT: begin
                    hi_o         = rot_w;
                    flg_o[FLG_N] = 1'b0;
                    flg_o[FLG_Z] = (rot_w == '0);
                    flg_o[FLG_T] = ovf;
                    flg_o[FLG_R] = flg_i[FLG_R] | ovf;
                end
                OP_DSHL: begin
                    hi_o         = dshl_w;
                    flg_o[FLG_N] = dshl_w[WORD_W-1];
                    flg_o[FLG_Z] = (dshl_w == '0);
                end
                default: begin
                    hi_o = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/tmul_unit.sv
// Top of the tribble multiply unit. Registers the core's results and flags
// when valid_i is high; synchronous active-low reset clears them.
// Assumes the operand width equals TRIB_W*N_TRIB.
module tmul_unit #(
    parameter int TRIB_W = 6,
    parameter int N_TRIB = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       valid_i,
    input  logic [3:0]                 op_i,
    input  logic [TRIB_W*N_TRIB-1:0]   opa_i,
    input  logic [TRIB_W*N_TRIB-1:0]   opb_i,
    input  logic [3:0]                 flg_i,
    output logic [TRIB_W*N_TRIB-1:0]   res_hi_o,
    output logic [TRIB_W*N_TRIB-1:0]   res_lo_o,
    output logic [3:0]                 flg_o
);
    import tmul_pkg::*;

    localparam int WORD_W = TRIB_W * N_TRIB;

    logic [WORD_W-1:0] hi_nxt, lo_nxt;
    logic [FLG_W-1:0]  flg_nxt;

    tmul_core #(.TRIB_W(TRIB_W), .N_TRIB(N_TRIB)) u_core (
        .op_i  (op_i),
        .opa_i (opa_i),
        .opb_i (opb_i),
        .flg_i (flg_i),
        .hi_o  (hi_nxt),
        .lo_o  (lo_nxt),
        .flg_o (flg_nxt)
    );

    // Output registers: capture on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi_o <= '0;
            res_lo_o <= '0;
            flg_o    <= '0;
        end else if (valid_i) begin
            res_hi_o <= hi_nxt;
            res_lo_o <= lo_nxt;
            flg_o    <= flg_nxt;
        end
    end

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (res_hi_o == '0 && res_lo_o == '0 && flg_o == '0));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(res_hi_o) && $stable(res_lo_o) && $stable(flg_o)));

    p_rot_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_MUL_HROT && flg_i[FLG_R]) |=> (flg_o[FLG_R] && !flg_o[FLG_N]));

    p_rot_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_MUL_HROT) |=> (flg_o[FLG_T] == (res_hi_o[TRIB_W-1:0] != '0)));

    p_split_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_SPLIT || (op_i >= OP_BCAST0 && op_i <= OP_BCAST5)))
        |=> (flg_o == $past(flg_i)));

    p_dshl_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_DSHL)
        |=> (flg_o[FLG_N] == res_hi_o[WORD_W-1] && flg_o[FLG_Z] == (res_hi_o == '0)
             && flg_o[FLG_T:FLG_R] == $past(flg_i[FLG_T:FLG_R])));

    p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i > OP_DSHL)
        |=> (res_hi_o == '0 && res_lo_o == '0 && flg_o == $past(flg_i)));

    p_single_lo_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i <= OP_MUL_HI || op_i == OP_DSHL)) |=> (res_lo_o == '0));

    p_mul_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_MUL_LO || op_i == OP_MUL_HI))
        |=> (!flg_o[FLG_N] && flg_o[FLG_Z] == (res_hi_o == '0)
             && flg_o[FLG_T:FLG_R] == $past(flg_i[FLG_T:FLG_R])));

endmodule

// File: tb/tmul_unit_bench.sv
module tmul_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [3:0]  op_i;
    logic [35:0] opa_i, opb_i;
    logic [3:0]  flg_i;
    logic [35:0] res_hi_o, res_lo_o;
    logic [3:0]  flg_o;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    tmul_unit u_tmul_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .flg_i(flg_i),
        .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .flg_o(flg_o)
    );

    // Expected behaviour computed from the requirements.
    task automatic model(input logic [3:0] op, input logic [35:0] a, input logic [35:0] b,
                         input logic [3:0] f, output logic [35:0] eh,
                         output logic [35:0] el, output logic [3:0] ef);
        logic [35:0] hw, lw, s;
        logic [5:0]  x;
        int unsigned p;
        hw = '0; lw = '0; eh = '0; el = '0; ef = f;
        for (int k = 0; k < 6; k++) begin
            x = (op >= 4 && op <= 9) ? a[6*(op-4) +: 6] : a[6*k +: 6];
            p = x * b[6*k +: 6];
            hw[6*k +: 6] = p[11:6];
            lw[6*k +: 6] = p[5:0];
        end
        case (op)
            4'd0: begin eh = lw; ef[3] = 0; ef[2] = (lw == 0); end
            4'd2: begin eh = hw; ef[3] = 0; ef[2] = (hw == 0); end
            4'd1: begin
                eh = {hw[29:0], hw[35:30]};
                ef[3] = 0; ef[2] = (eh == 0);
                ef[1] = (eh[5:0] != 0);
                ef[0] = f[0] | ef[1];
            end
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin eh = hw; el = lw; end
            4'd10: begin
                s = b + {35'b0, f[1]};
                eh = {s[29:0], a[35:30]};
                ef[3] = eh[35]; ef[2] = (eh == 0);
            end
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [3:0] op, input int part);
        if (part == 1) return (op <= 2 || op == 10) ? "R12" : (op == 3 ? "R5" : (op <= 9 ? "R6" : "R11"));
        case (op)
            4'd0: return "R1";
            4'd1: return part == 2 ? "R4" : "R3";
            4'd2: return "R2";
            4'd3: return "R5";
            4'd10: return part == 2 ? "R8" : "R7";
            default: return (op <= 9) ? "R6" : "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Applies one operation, then checks all outputs one cycle later.
    task automatic run_op(input logic [3:0] op, input logic [35:0] a,
                          input logic [35:0] b, input logic [3:0] f);
        logic [35:0] eh, el;
        logic [3:0]  ef;
        model(op, a, b, f, eh, el, ef);
        @(negedge clk);
        valid_i = 1; op_i = op; opa_i = a; opb_i = b; flg_i = f;
        @(negedge clk);
        valid_i = 0;
        check(tag_of(op, 0), res_hi_o, eh);
        check(tag_of(op, 1), res_lo_o, el);
        check(tag_of(op, 2), {32'b0, flg_o}, {32'b0, ef});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        logic [35:0] h0, l0;
        logic [3:0]  f0;
        void'($urandom(32'd2718));
        rst_n = 0; valid_i = 1; op_i = 4'd0; opa_i = '1; opb_i = '1; flg_i = 4'hF;
        repeat (3) @(negedge clk);
        // R10: reset state despite an active strobe
        check("R10", res_hi_o, '0);
        check("R10", res_lo_o, '0);
        check("R10", {32'b0, flg_o}, '0);
        rst_n = 1; valid_i = 0;

        // R1/R2: all-ones lanes, 63*63 = 0xF81
        run_op(4'd0, '1, '1, 4'b1011);
        run_op(4'd2, '1, '1, 4'b1000);
        run_op(4'd0, 36'h0, 36'h123456789, 4'b1111);
        // R3/R4: no overflow keeps R, overflow sets T and R
        run_op(4'd1, 36'h000000FFF, 36'h000000FFF, 4'b0001);
        run_op(4'd1, 36'h000000FFF, 36'h000000FFF, 4'b0000);
        run_op(4'd1, 36'hFC0000000, 36'hFC0000000, 4'b0000);
        run_op(4'd1, 36'h0, 36'h0, 4'b1010);
        // R5/R6: every broadcast lane
        for (int k = 3; k <= 9; k++) run_op(4'(k), 36'hFEDCBA987, 36'h3F1C2A05B, 4'b0110);
        // R7/R8: carry wrap gives zero sum
        run_op(4'd10, 36'hABC000000, '1, 4'b0010);
        run_op(4'd10, 36'h000000000, 36'h7FFFFFFFF, 4'b0010);
        run_op(4'd10, 36'h0, 36'h0, 4'b0001);
        // R11: undefined codes
        for (int k = 11; k <= 15; k++) run_op(4'(k), '1, '1, 4'(k));

        // R9: scramble inputs with strobe low, outputs hold
        run_op(4'd3, 36'h123456789, 36'hFEDCBA987, 4'b1001);
        h0 = res_hi_o; l0 = res_lo_o; f0 = flg_o;
        op_i = 4'd10; opa_i = '1; opb_i = 36'h5; flg_i = 4'h6;
        repeat (2) @(negedge clk);
        check("R9", res_hi_o, h0);
        check("R9", res_lo_o, l0);
        check("R9", {32'b0, flg_o}, {32'b0, f0});

        // Random mix, sometimes with a replicated small factor
        for (int i = 0; i < 600; i++) begin
            logic [35:0] a, b;
            logic [5:0]  sm;
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            sm = 6'($urandom);
            if ($urandom % 3 == 0) b = {6{sm}};
            run_op(4'($urandom % 16), a, b, 4'($urandom));
        end

        // R10: reset mid-run clears
        run_op(4'd2, '1, '1, 4'hF);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        check("R10", res_hi_o, '0);
        check("R10", {32'b0, flg_o}, '0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule